// File: doc/BRIEF.md
# Reset Button and Serial Speed Selector

This controller sits beside an in-system programming engine and gives a single push button two jobs. A short press drives a target-reset request for a fixed pulse length. Holding the button well past that pulse opens a menu of four serial clock speeds. Further presses step through the speeds in a ring. When a full menu window passes with no press, the shown speed is committed and a one-clock store strobe asks the surrounding logic to save it.

All behaviour advances on a periodic tick, nominally 10 ms, which is a one-clock enable input. The button is sampled only on that tick, so the tick also serves as a coarse debounce. An active-low status LED shows the state. It is solid while the reset pulse is driven, dark when idle or waiting, and blinks at a rate that names the speed while the menu is open.

The speed code is two bits: 0 selects the system clock divided by 128, 1 divided by 64, 2 divided by 16 and 3 divided by 4. Code 3 is the default.

Top module: `btn_speed_ctrl`

## Requirements
- R1: After reset, tgt_rst_o is 0, led_no is 1, store_o is 0 and speed_o is 3 (divide by 4).
- R2: The button is read only on a tick. A press event is a 0-to-1 change between successive tick samples and a release event is a 1-to-0 change. Button activity that starts and ends between ticks has no effect.
- R3: A press event while idle sets tgt_rst_o to 1 and turns the LED fully on (led_no 0) on that tick.
- R4: If the button is still held, tgt_rst_o returns to 0 and the LED goes dark on the PULSE_TICKS-th tick after the press (default 5).
- R5: A release event during the reset pulse ends the pulse at once and returns to idle.
- R6: After the pulse, a release before MENU_TICKS further ticks (default 500) returns to idle with no store. Otherwise, on that tick the menu opens at the code given by cur_speed_i.
- R7: Each press event in the menu advances the code 0, 1, 2, 3, then back to 0, and restarts the MENU_TICKS window.
- R8: On the MENU_TICKS-th tick after the last menu entry or press, speed_o takes the shown code, store_o is 1 for exactly one clock, and the block returns to idle with the LED dark. speed_o changes at no other time.
- R9: The LED is lit (led_no 0) when mask AND (n OR 0x80) is nonzero. Here n is the number of ticks since reset modulo 256, counted before the current tick, and mask is 0x80 in the pulse, 0x00 when idle or waiting, and 0x20, 0x10, 0x08 or 0x04 in the menu for codes 0, 1, 2 and 3.
- R10: When a timeout and a button event fall on the same tick, the timeout wins and the button event is dropped.
- R11: A release event while the menu is open is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-clock time-base enable (10 ms nominal) |
| btn_i | input | 1 | Button level, 1 = pressed |
| cur_speed_i | input | 2 | Speed code currently in use; it seeds the menu |
| tgt_rst_o | output | 1 | Target reset request, 1 = hold target in reset |
| led_no | output | 1 | Status LED, 0 = lit |
| speed_o | output | 2 | Last committed speed code |
| store_o | output | 1 | One-clock request to save speed_o |

## Verification
Every output is registered from the clock edge that samples a tick. The bench raises tick_i on a falling edge and reads all outputs at the next falling edge, so each tick's result is checked one half-cycle after it is due. The store strobe is read again one clock later to confirm it lasts a single cycle. Pulse length, menu timeout and the same-tick race are checked by counting ticks in the bench from the press or the last menu entry. Blink patterns are compared at every tick against the bench's own tick count.

// File: rtl/btn_speed_pkg.sv
package btn_speed_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_WAIT = 2'd2,
    ST_MENU = 2'd3
  } ctl_state_e;

  localparam logic [7:0] MASK_DARK  = 8'h00;
  localparam logic [7:0] MASK_SOLID = 8'h80;

  // code 0 blinks slowest (bit 5), code 3 fastest (bit 2)
  function automatic logic [7:0] speed_mask(input logic [1:0] code);
    return 8'h20 >> code;
  endfunction
endpackage

// File: rtl/bsf_edge_det.sv
module bsf_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic btn_i,
  output logic press_o,
  output logic release_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     prev_q <= 1'b0;
    else if (tick_i) prev_q <= btn_i;
  end

  assign press_o   = tick_i &  btn_i & ~prev_q;
  assign release_o = tick_i & ~btn_i &  prev_q;

  // R2
  edge_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(press_o && release_o));
  // R2
  edge_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (press_o || release_o) |-> tick_i);
endmodule

// File: rtl/bsf_countdown.sv
module bsf_countdown #(
  parameter int W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic         clear_i,
  input  logic [W-1:0] load_val_i,
  output logic         expire_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clear_i)                cnt_q <= '0;
    else if (load_i)                 cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = tick_i && (cnt_q == W'(1));

  // R8
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i && !clear_i) |=> $stable(cnt_q));
  // R4
  expire_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && !load_i && !clear_i) |=> (cnt_q == '0));
endmodule

// File: rtl/bsf_led_blink.sv
module bsf_led_blink
  import btn_speed_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [7:0] mask_i,
  output logic       led_no
);
  logic [7:0] phase_q;
  logic       led_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      led_q   <= 1'b1;
    end else if (tick_i) begin
      phase_q <= phase_q + 8'd1;
      led_q   <= ~|(mask_i & (phase_q | 8'h80));
    end
  end

  assign led_no = led_q;

  // R9
  led_solid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && mask_i == MASK_SOLID) |=> !led_no);
  // R9
  led_dark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && mask_i == MASK_DARK) |=> led_no);
endmodule

// File: rtl/btn_speed_ctrl.sv
module btn_speed_ctrl
  import btn_speed_pkg::*;
#(
  parameter int          PULSE_TICKS   = 5,
  parameter int          MENU_TICKS    = 500,
  parameter logic [1:0]  DEFAULT_SPEED = 2'd3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       btn_i,
  input  logic [1:0] cur_speed_i,
  output logic       tgt_rst_o,
  output logic       led_no,
  output logic [1:0] speed_o,
  output logic       store_o
);
  localparam int TMR_MAX = (PULSE_TICKS > MENU_TICKS) ? PULSE_TICKS : MENU_TICKS;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam logic [TMR_W-1:0] PULSE_V = TMR_W'(PULSE_TICKS);
  localparam logic [TMR_W-1:0] MENU_V  = TMR_W'(MENU_TICKS);

  logic press, rel, expire;
  logic ev_press, ev_rel;
  ctl_state_e state_q, state_d;
  logic [1:0] sel_q, sel_d;
  logic rst_q, rst_d;
  logic [1:0] speed_q;
  logic store_q, commit;
  logic tmr_load, tmr_clear;
  logic [TMR_W-1:0] tmr_val;
  logic [7:0] mask_d;

  bsf_edge_det i_edge (
    .clk_i, .rst_ni, .tick_i, .btn_i,
    .press_o(press), .release_o(rel)
  );

  bsf_countdown #(.W(TMR_W)) i_tmr (
    .clk_i, .rst_ni, .tick_i,
    .load_i(tmr_load), .clear_i(tmr_clear), .load_val_i(tmr_val),
    .expire_o(expire)
  );

  // timeout is resolved last: it overrides a same-tick edge
  assign ev_press = press & ~expire;
  assign ev_rel   = rel   & ~expire;

  always_comb begin
    state_d   = state_q;
    sel_d     = sel_q;
    rst_d     = rst_q;
    commit    = 1'b0;
    tmr_load  = 1'b0;
    tmr_clear = 1'b0;
    tmr_val   = MENU_V;
    unique case (state_q)
      ST_IDLE: if (ev_press) begin
        state_d  = ST_HOLD;
        rst_d    = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = PULSE_V;
      end
      ST_HOLD: if (expire) begin
        state_d  = ST_WAIT;
        rst_d    = 1'b0;
        tmr_load = 1'b1;
      end else if (ev_rel) begin
        state_d   = ST_IDLE;
        rst_d     = 1'b0;
        tmr_clear = 1'b1;
      end
      ST_WAIT: if (expire) begin
        state_d  = ST_MENU;
        sel_d    = cur_speed_i;
        tmr_load = 1'b1;
      end else if (ev_rel) begin
        state_d   = ST_IDLE;
        tmr_clear = 1'b1;
      end
      ST_MENU: if (expire) begin
        state_d   = ST_IDLE;
        commit    = 1'b1;
        tmr_clear = 1'b1;
      end else if (ev_press) begin
        sel_d    = sel_q + 2'd1;
        tmr_load = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (state_d)
      ST_HOLD: mask_d = MASK_SOLID;
      ST_MENU: mask_d = speed_mask(sel_d);
      default: mask_d = MASK_DARK;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sel_q   <= DEFAULT_SPEED;
      rst_q   <= 1'b0;
      speed_q <= DEFAULT_SPEED;
      store_q <= 1'b0;
    end else begin
      state_q <= state_d;
      sel_q   <= sel_d;
      rst_q   <= rst_d;
      store_q <= commit;
      if (commit) speed_q <= sel_q;
    end
  end

  bsf_led_blink i_led (
    .clk_i, .rst_ni, .tick_i,
    .mask_i(mask_d), .led_no
  );

  assign tgt_rst_o = rst_q;
  assign speed_o   = speed_q;
  assign store_o   = store_q;

  // R8
  store_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_o |=> !store_o);
  // R8
  store_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_o |-> (state_q == ST_IDLE && !tgt_rst_o));
  // R8
  speed_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(speed_o) |-> store_o);
  // R3
  rst_in_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_rst_o |-> (state_q == ST_HOLD));
  // R2
  state_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(state_q));
  // R10
  race_tmo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD && expire) |=> (state_q == ST_WAIT));
endmodule

// File: tb/test_btn_speed_ctrl.sv
module test_btn_speed_ctrl;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b0;
  logic btn_i = 1'b0;
  logic [1:0] cur_speed_i = 2'd3;
  logic tgt_rst_o, led_no, store_o;
  logic [1:0] speed_o;

  int n_chk = 0;
  int n_fail = 0;
  int tick_cnt = 0;
  logic [7:0] ph;
  bit done = 0;

  always #10 clk = ~clk;

  btn_speed_ctrl i_btn_speed_ctrl (
    .clk_i(clk), .rst_ni, .tick_i, .btn_i, .cur_speed_i,
    .tgt_rst_o, .led_no, .speed_o, .store_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_tick();
    @(negedge clk);
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    ph = tick_cnt[7:0];
    tick_cnt++;
  endtask

  function automatic logic exp_led(input logic [7:0] mask);
    return ~|(mask & (ph | 8'h80));
  endfunction

  // n ticks: LED follows mask, no store, no reset request
  task automatic run_chk(input int n, input logic [7:0] mask, input string req);
    int bad = 0;
    int first = -1;
    for (int i = 0; i < n; i++) begin
      do_tick();
      if (led_no !== exp_led(mask) || store_o !== 1'b0 || tgt_rst_o !== 1'b0) begin
        bad++;
        if (first < 0) first = i;
      end
    end
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic t_reset();
    chk(tgt_rst_o === 1'b0, "R1 rst", tgt_rst_o, 0);
    chk(led_no === 1'b1, "R1 led", led_no, 1);
    chk(store_o === 1'b0, "R1 store", store_o, 0);
    chk(speed_o === 2'd3, "R1 speed", speed_o, 3);
  endtask

  task automatic t_between();
    @(negedge clk);
    btn_i = 1'b1;
    repeat (5) @(negedge clk);
    btn_i = 1'b0;
    do_tick();
    chk(tgt_rst_o === 1'b0, "R2 glitch ignored", tgt_rst_o, 0);
    run_chk(3, 8'h00, "R2 stays idle");
  endtask

  task automatic t_short();
    btn_i = 1'b1;
    do_tick();
    chk(tgt_rst_o === 1'b1, "R3 rst on press", tgt_rst_o, 1);
    chk(led_no === 1'b0, "R3 led solid", led_no, 0);
    do_tick();
    do_tick();
    btn_i = 1'b0;
    do_tick();
    chk(tgt_rst_o === 1'b0, "R5 early release", tgt_rst_o, 0);
    chk(led_no === 1'b1, "R5 led dark", led_no, 1);
    run_chk(10, 8'h00, "R5 idle after release");
  endtask

  task automatic t_pulse();
    int bad = 0;
    btn_i = 1'b1;
    do_tick();
    for (int i = 1; i < 5; i++) begin
      do_tick();
      if (tgt_rst_o !== 1'b1 || led_no !== 1'b0) bad++;
    end
    chk(bad == 0, "R4 pulse held", bad, 0);
    do_tick();
    chk(tgt_rst_o === 1'b0, "R4 pulse end", tgt_rst_o, 0);
    chk(led_no === 1'b1, "R4 led dark", led_no, 1);
    run_chk(5, 8'h00, "R6 waiting");
    btn_i = 1'b0;
    run_chk(600, 8'h00, "R6 release before menu");
  endtask

  task automatic press_once();
    btn_i = 1'b1;
    do_tick();
    btn_i = 1'b0;
  endtask

  task automatic t_menu();
    cur_speed_i = 2'd1;
    btn_i = 1'b1;
    do_tick();
    repeat (5) do_tick();
    run_chk(499, 8'h00, "R6 wait held");
    run_chk(1, 8'h10, "R6 menu at cur speed");
    btn_i = 1'b0;
    run_chk(40, 8'h10, "R11 release ignored");
    press_once();
    run_chk(20, 8'h08, "R7 code 2");
    press_once();
    run_chk(20, 8'h04, "R7 code 3");
    press_once();
    run_chk(70, 8'h20, "R7 wrap to 0");
    run_chk(429, 8'h20, "R7 window restarted");
    do_tick();
    chk(store_o === 1'b1, "R8 store", store_o, 1);
    chk(speed_o === 2'd0, "R8 speed", speed_o, 0);
    chk(led_no === 1'b1, "R8 led dark", led_no, 1);
    @(negedge clk);
    chk(store_o === 1'b0, "R8 store one clock", store_o, 0);
    run_chk(5, 8'h00, "R8 idle");
    chk(speed_o === 2'd0, "R8 speed kept", speed_o, 0);
  endtask

  task automatic t_race();
    cur_speed_i = 2'd3;
    btn_i = 1'b1;
    do_tick();
    repeat (4) do_tick();
    btn_i = 1'b0;
    do_tick();
    chk(tgt_rst_o === 1'b0, "R10 pulse ends", tgt_rst_o, 0);
    run_chk(499, 8'h00, "R10 release lost");
    run_chk(16, 8'h04, "R10 menu opens");
    run_chk(484, 8'h04, "R10 menu window");
    do_tick();
    chk(store_o === 1'b1, "R10 store", store_o, 1);
    chk(speed_o === 2'd3, "R10 speed", speed_o, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_between();
    t_short();
    t_pulse();
    t_menu();
    t_race();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule